// File: doc/BRIEF.md
# Multi-Context Lookup-Table Array Cluster

The cluster holds sixteen reconfigurable cells. Each cell computes one bit with a 4-input lookup table. The cell's own configuration memory holds four complete configuration words, called contexts. A 2-bit context number arrives on `ctx_id` and goes to every cell. In each cycle it picks which stored word drives each cell's lookup table, input selection and output mode. Because of this, the same hardware can compute a different function in every cycle, and cells can hold different functions under the same context number.

Each lookup-table input picks one source from a shared pool. The pool holds the four external inputs and the registered outputs of all sixteen cells, so cells chain only through registers. A word-wide load port writes one cell's full configuration word into one context per accepted beat. The load port is a valid/ready stream: a beat transfers on a rising edge where `cfg_valid` and `cfg_ready` are both high. While `cfg_ready` is low the sender must hold the beat stable. A beat aimed at the context that is being computed is parked in a one-entry holding slot instead of being written. The slot back-pressures the port until the beat can be written safely. `ctx_id`, `ext_in`, `cfg_pending` and `elem_out` are plain signals, not streams.

Top module: `mctx_cluster`

## Requirements
- R1: After reset `elem_out` is 0, `cfg_ready` is 1 and `cfg_pending` is 0, every element register is 0, and every context of every cell holds 0, so all outputs stay 0 under any `ctx_id` until a load occurs.
- R2: In each cycle every cell uses the stored word indexed by the current `ctx_id`. A new `ctx_id` value takes effect in the cycle it is presented, and it may change on every cycle.
- R3: Configuration word layout: bit 36 selects the output mode, bits 35:20 hold the truth table, and bits 19:0 hold four 5-bit source selects, with input i at bits 5i+4:5i. The lookup result is truth-table bit {in3,in2,in1,in0}.
- R4: Source select code encoding: codes 0 to 3 pick `ext_in[code]`, codes 4 to 19 pick the registered output of cell code-4, and codes 20 to 31 give constant 0.
- R5: Each cell's register captures its lookup result on every rising edge. With the mode bit at 1, `elem_out[e]` shows that register. With the mode bit at 0, it shows the lookup result combinationally.
- R6: Words stored under the same context number are independent per cell, so cells compute different functions in the same cycle.
- R7: An accepted beat whose `cfg_ctx` differs from the current `ctx_id` replaces the whole word of cell `cfg_elem`, context `cfg_ctx`, at that edge. It has no effect on outputs computed under the active context.
- R8: An accepted beat whose `cfg_ctx` equals the current `ctx_id` is held rather than written. `cfg_pending` goes high after that edge and `cfg_ready` is low while it stays high. The held word is written at the first edge where `ctx_id` differs from its context, and `cfg_pending` drops after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctx_id | input | 2 | Context number sent to all cells |
| ext_in | input | 4 | External source bits |
| cfg_valid | input | 1 | Load beat valid |
| cfg_ready | output | 1 | Load port can accept a beat |
| cfg_elem | input | 4 | Target cell of the beat |
| cfg_ctx | input | 2 | Target context of the beat |
| cfg_word | input | 37 | Full configuration word |
| cfg_pending | output | 1 | A beat for the active context is waiting |
| elem_out | output | 16 | One output bit per cell |

## Verification
Each context carries a different function family: a two-input AND of external bits, a four-input parity that is registered on odd cells, a chain of toggling register bits, and a neighbour copy. An output that matches the model therefore shows that the correct word was indexed, and not merely a plausible logic value. A table of context and input pairs is walked while the context changes every step. This separates same-cycle selection from a one-cycle-late selection, and combinational output from registered output. The same walk runs again while beats rewrite non-active contexts, which exposes any leak of a background write into live outputs. Last, a beat is aimed at the live context and the context is held, then moved, then returned, to show the hold, the release edge and the back-pressure.

// File: rtl/mctx_pkg.sv
package mctx_pkg;
  localparam int N_ELEM = 16;
  localparam int N_CTX  = 4;
  localparam int N_EXT  = 4;
  localparam int LUT_K  = 4;

  localparam int CTX_W  = $clog2(N_CTX);
  localparam int ELEM_W = $clog2(N_ELEM);
  localparam int N_SRC  = N_EXT + N_ELEM;
  localparam int SEL_W  = $clog2(N_SRC);
  localparam int TT_W   = 1 << LUT_K;

  typedef struct packed {
    logic                         reg_out;
    logic [TT_W-1:0]              tt;
    logic [LUT_K-1:0][SEL_W-1:0]  sel;
  } cfg_t;

  localparam int CFG_W = $bits(cfg_t);
endpackage

// File: rtl/mctx_store.sv
module mctx_store
  import mctx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CTX_W-1:0] wr_ctx,
  input  cfg_t             wr_data,
  input  logic [CTX_W-1:0] rd_ctx,
  output cfg_t             rd_data
);
  cfg_t mem [N_CTX];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_CTX; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[wr_ctx] <= wr_data;
    end
  end

  assign rd_data = mem[rd_ctx];

  for (genvar c = 0; c < N_CTX; c++) begin : g_chk
    AST_CTX_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && wr_ctx == CTX_W'(c)) |=> $stable(mem[c])); // R7
  end
endmodule

// File: rtl/mctx_elem.sv
module mctx_elem
  import mctx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  cfg_t             cfg,
  input  logic [N_SRC-1:0] src,
  output logic             q,
  output logic             y
);
  localparam int PAD_W = 1 << SEL_W;

  logic [PAD_W-1:0] src_pad;
  logic [LUT_K-1:0] idx;
  logic             lut_val;

  assign src_pad = {{(PAD_W-N_SRC){1'b0}}, src};

  for (genvar k = 0; k < LUT_K; k++) begin : g_in
    assign idx[k] = src_pad[cfg.sel[k]];
  end

  assign lut_val = cfg.tt[idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= lut_val;
  end

  assign y = cfg.reg_out ? q : lut_val;
endmodule

// File: rtl/mctx_loader.sv
module mctx_loader
  import mctx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CTX_W-1:0]  ctx_id,
  input  logic              cfg_valid,
  output logic              cfg_ready,
  input  logic [ELEM_W-1:0] cfg_elem,
  input  logic [CTX_W-1:0]  cfg_ctx,
  input  cfg_t              cfg_word,
  output logic              cfg_pending,
  output logic              wr_en,
  output logic [ELEM_W-1:0] wr_elem,
  output logic [CTX_W-1:0]  wr_ctx,
  output cfg_t              wr_data
);
  logic              pend_q;
  logic [ELEM_W-1:0] pend_elem;
  logic [CTX_W-1:0]  pend_ctx;
  cfg_t              pend_data;
  logic              accept, hit, commit;

  assign accept = cfg_valid && !pend_q;
  assign hit    = (cfg_ctx == ctx_id);
  assign commit = pend_q && (pend_ctx != ctx_id);

  always_comb begin
    wr_en   = commit || (accept && !hit);
    wr_elem = commit ? pend_elem : cfg_elem;
    wr_ctx  = commit ? pend_ctx  : cfg_ctx;
    wr_data = commit ? pend_data : cfg_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q    <= 1'b0;
      pend_elem <= '0;
      pend_ctx  <= '0;
      pend_data <= '0;
    end else if (commit) begin
      pend_q <= 1'b0;
    end else if (accept && hit) begin
      pend_q    <= 1'b1;
      pend_elem <= cfg_elem;
      pend_ctx  <= cfg_ctx;
      pend_data <= cfg_word;
    end
  end

  assign cfg_ready   = !pend_q;
  assign cfg_pending = pend_q;

  AST_NO_WRITE_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_ctx != ctx_id)); // R7
  AST_PEND_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && cfg_ready && cfg_ctx == ctx_id) |=> cfg_pending); // R8
  AST_PEND_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && pend_ctx == ctx_id) |=> (pend_q && $stable(pend_data))); // R8
  AST_PEND_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && pend_ctx != ctx_id) |=> !pend_q); // R8
endmodule

// File: rtl/mctx_cluster.sv
module mctx_cluster
  import mctx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CTX_W-1:0]  ctx_id,
  input  logic [N_EXT-1:0]  ext_in,
  input  logic              cfg_valid,
  output logic              cfg_ready,
  input  logic [ELEM_W-1:0] cfg_elem,
  input  logic [CTX_W-1:0]  cfg_ctx,
  input  logic [CFG_W-1:0]  cfg_word,
  output logic              cfg_pending,
  output logic [N_ELEM-1:0] elem_out
);
  logic              ld_wr;
  logic [ELEM_W-1:0] ld_elem;
  logic [CTX_W-1:0]  ld_ctx;
  cfg_t              ld_data;
  logic [N_ELEM-1:0] q_all;
  logic [N_SRC-1:0]  src;

  assign src = {q_all, ext_in};

  mctx_loader u_loader (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctx_id      (ctx_id),
    .cfg_valid   (cfg_valid),
    .cfg_ready   (cfg_ready),
    .cfg_elem    (cfg_elem),
    .cfg_ctx     (cfg_ctx),
    .cfg_word    (cfg_t'(cfg_word)),
    .cfg_pending (cfg_pending),
    .wr_en       (ld_wr),
    .wr_elem     (ld_elem),
    .wr_ctx      (ld_ctx),
    .wr_data     (ld_data)
  );

  for (genvar e = 0; e < N_ELEM; e++) begin : g_elem
    cfg_t cur;
    logic we;
    assign we = ld_wr && (ld_elem == ELEM_W'(e));

    mctx_store u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (we),
      .wr_ctx  (ld_ctx),
      .wr_data (ld_data),
      .rd_ctx  (ctx_id),
      .rd_data (cur)
    );

    mctx_elem u_cell (
      .clk   (clk),
      .rst_n (rst_n),
      .cfg   (cur),
      .src   (src),
      .q     (q_all[e]),
      .y     (elem_out[e])
    );
  end

  AST_READY_LOW_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_pending |-> !cfg_ready); // R8
endmodule

// File: tb/mctx_cluster_tb.sv
`timescale 1ns/1ps
module mctx_cluster_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  ctx_r = '0;
  logic [3:0]  ext_r = '0;
  logic        v_r = 1'b0;
  logic [3:0]  el_r = '0;
  logic [1:0]  cx_r = '0;
  logic [36:0] wd_r = '0;
  logic        cfg_ready, cfg_pending;
  logic [15:0] elem_out;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  logic [36:0] mem_m [16][4];
  logic [15:0] qm;
  logic        pm;
  logic [3:0]  p_el;
  logic [1:0]  p_cx;
  logic [36:0] p_wd;

  // {ctx[1:0], ext[3:0]}
  localparam logic [5:0] VEC [24] = '{
    6'b00_0011, 6'b01_0101, 6'b10_1111, 6'b11_0001,
    6'b00_1100, 6'b01_1110, 6'b10_0000, 6'b11_1001,
    6'b01_0110, 6'b00_1111, 6'b11_0100, 6'b10_1010,
    6'b10_0111, 6'b10_0111, 6'b01_1011, 6'b01_1011,
    6'b00_0110, 6'b11_1111, 6'b00_1001, 6'b11_0000,
    6'b01_1000, 6'b10_0101, 6'b00_1110, 6'b11_1101};

  always #2.5 clk = ~clk;

  mctx_cluster u_dut (
    .clk(clk), .rst_n(rst_n), .ctx_id(ctx_r), .ext_in(ext_r),
    .cfg_valid(v_r), .cfg_ready(cfg_ready), .cfg_elem(el_r),
    .cfg_ctx(cx_r), .cfg_word(wd_r), .cfg_pending(cfg_pending),
    .elem_out(elem_out));

  function automatic logic [36:0] mk(input logic r, input logic [15:0] tt,
      input logic [4:0] s3, input logic [4:0] s2, input logic [4:0] s1, input logic [4:0] s0);
    return {r, tt, s3, s2, s1, s0};
  endfunction

  // R6: each cell gets its own variant of a context's function
  function automatic logic [36:0] word_for(input int e, input int c);
    case (c)
      0: return mk(1'b0, 16'h8888, 5'd31, 5'd31, 5'((e+1)%4), 5'(e%4));
      1: return mk(1'(e%2), 16'h6996, 5'd3, 5'd2, 5'd1, 5'd0);
      2: return (e == 0) ? mk(1'b1, 16'h5555, 5'd31, 5'd31, 5'd31, 5'd4)
                         : mk(1'b1, 16'h6666, 5'd31, 5'd31, 5'(4+e-1), 5'(4+e));
      default: return (e == 0) ? mk(1'b0, 16'hAAAA, 5'd31, 5'd31, 5'd31, 5'd0)
                               : mk(1'b0, 16'hAAAA, 5'd31, 5'd31, 5'd31, 5'(4+e-1));
    endcase
  endfunction

  function automatic logic pick(input logic [4:0] s);
    if (s < 5'd4) return ext_r[s[1:0]];
    if (s < 5'd20) return qm[s-5'd4];
    return 1'b0;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [36:0] act, input logic [36:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // inputs already driven after a falling edge
  task automatic step(input string tag);
    logic [15:0] lut_m, y_m;
    logic [36:0] w;
    logic [3:0]  idx;
    #1;
    for (int e = 0; e < 16; e++) begin
      w = mem_m[e][ctx_r];
      idx = {pick(w[19:15]), pick(w[14:10]), pick(w[9:5]), pick(w[4:0])};
      lut_m[e] = w[20+idx];
      y_m[e] = w[36] ? qm[e] : lut_m[e];
    end
    chk(elem_out === y_m, tag, 37'(elem_out), 37'(y_m));
    chk(cfg_ready === !pm && cfg_pending === pm, "R8 ready/pending",
        37'({cfg_ready, cfg_pending}), 37'({!pm, pm}));
    @(posedge clk);
    qm = lut_m;
    if (pm && p_cx != ctx_r) begin
      mem_m[p_el][p_cx] = p_wd;
      pm = 1'b0;
    end else if (v_r && !pm) begin
      if (cx_r != ctx_r) mem_m[el_r][cx_r] = wd_r;
      else begin pm = 1'b1; p_el = el_r; p_cx = cx_r; p_wd = wd_r; end
    end
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    for (int e = 0; e < 16; e++) for (int c = 0; c < 4; c++) mem_m[e][c] = '0;
    qm = '0; pm = 1'b0; p_el = '0; p_cx = '0; p_wd = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(elem_out === 16'h0 && cfg_ready === 1'b1 && cfg_pending === 1'b0, "R1 reset",
        37'({elem_out, cfg_ready, cfg_pending}), 37'({16'h0, 1'b1, 1'b0}));
    @(negedge clk);
    // R1: all contexts empty
    for (int c = 0; c < 4; c++) begin
      ctx_r = 2'(c); ext_r = 4'hF - 4'(c);
      step("R1 empty contexts");
    end
    // load context 0 while context 3 runs
    ctx_r = 2'd3;
    for (int e = 0; e < 16; e++) begin
      v_r = 1'b1; el_r = 4'(e); cx_r = 2'd0; wd_r = word_for(e, 0); ext_r = 4'(e);
      step("R7 load idle context");
    end
    // background load of contexts 1..3 while context 0 computes
    ctx_r = 2'd0;
    for (int c = 1; c < 4; c++) for (int e = 0; e < 16; e++) begin
      v_r = 1'b1; el_r = 4'(e); cx_r = 2'(c); wd_r = word_for(e, c); ext_r = 4'(e*3+c);
      step("R7 background load under live context");
    end
    v_r = 1'b0;
    // vector walk, context changing per step
    for (int i = 0; i < 24; i++) begin
      ctx_r = VEC[i][5:4]; ext_r = VEC[i][3:0];
      step("R2 R3 R4 R5 R6 vector walk");
    end
    // context every cycle with concurrent loads into other contexts
    for (int i = 0; i < 40; i++) begin
      ctx_r = 2'(i % 4); ext_r = 4'(i * 5);
      v_r = 1'b1; el_r = 4'(i % 16); cx_r = 2'((i + 2) % 4);
      wd_r = word_for((i + 7) % 16, (i + 1) % 4);
      step("R2 R7 switching with loads");
    end
    v_r = 1'b0;
    // deferred write to the live context
    ctx_r = 2'd1; ext_r = 4'h6;
    v_r = 1'b1; el_r = 4'd5; cx_r = 2'd1; wd_r = mk(1'b0, 16'hFFFF, 5'd31, 5'd31, 5'd31, 5'd31);
    step("R8 beat to live context");
    v_r = 1'b0;
    chk(cfg_pending === 1'b1 && cfg_ready === 1'b0, "R8 held after edge",
        37'({cfg_pending, cfg_ready}), 37'({1'b1, 1'b0}));
    for (int i = 0; i < 3; i++) begin
      ext_r = 4'(i + 9);
      step("R8 live output unchanged while held");
    end
    ctx_r = 2'd2;
    step("R8 release cycle");
    chk(cfg_pending === 1'b0 && cfg_ready === 1'b1, "R8 released",
        37'({cfg_pending, cfg_ready}), 37'({1'b0, 1'b1}));
    ctx_r = 2'd1;
    step("R8 committed word in use");
    chk(elem_out[5] === 1'b1, "R8 cell 5 constant one", 37'(elem_out[5]), 37'(1));
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule